// File: doc/BRIEF.md
# Sticky-Preserving Mantissa Right Shifter

This block takes a 128-bit floating-point working mantissa and shifts it right by a variable amount. Every bit that drops off the low end is folded into a sticky flag, so a later rounding step still knows whether anything nonzero was lost. An incoming sticky bit is merged into that flag as well. The mantissa is seen as four 32-bit words, with word 0 as the most significant (bits 127:96) and word 3 as the least significant (bits 31:0). The shift is done in two steps: whole words move first, then a residual shift of 0 to 31 bits is applied across word boundaries.

When the shift amount reaches the significant-bit count (parameter `NSIG`, default 115), the block skips the shift. It returns an all-zero mantissa and forces sticky to one. A shift amount of zero is illegal. It raises an error flag and passes the data through unchanged. A NaN is shifted like any other value, and its sticky result has no meaning. Rounding, exponent adjustment and operand classification are left to the surrounding datapath.

Both sides of the block use a valid/ready handshake. An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register, with `out_valid` set, from that edge on. The result stays there unchanged until a rising edge where `out_ready` is high. `in_ready` is high whenever that register is empty or is being drained in the same cycle. With `out_ready` tied high, `out_valid` is therefore a one-cycle done pulse one clock after each accepted operand.

Top module: `mant_rshift_sticky`

## Requirements
- R1: For an accepted amount `a` with 1 <= a < NSIG, `out_mant` equals `in_mant` shifted right by `a` bit positions as a single 128-bit value, with zeros entering at bit 127. Word 0 is bits 127:96 and word 3 is bits 31:0.
- R2: For 1 <= a < NSIG, `out_sticky` is the OR of `in_sticky` and every bit of `in_mant` at positions a-1 down to 0. The sticky result is 1 whenever `in_sticky` is 1.
- R3: For an accepted amount `a` >= NSIG (default 115), `out_mant` is all zero, `out_sticky` is 1 and `out_err` is 0.
- R4: For an accepted amount of zero, `out_err` is 1 and `out_mant` and `out_sticky` equal `in_mant` and `in_sticky` unchanged.
- R5: The result of an operand accepted on a rising edge is presented, with `out_valid` high, from that edge on. With `out_ready` high, `out_valid` falls again one cycle later unless a new operand was accepted.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_mant`, `out_sticky` and `out_err` hold their values.
- R7: A synchronous active-high `rst` clears `out_valid`, `out_mant`, `out_sticky` and `out_err` to zero, which leaves `in_ready` high.
- R8: `out_err` is 0 for every accepted nonzero shift amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present on the input side |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_mant | input | 128 | Mantissa to shift, word 0 in bits 127:96 |
| in_sticky | input | 1 | Sticky bit carried in with the operand |
| in_amt | input | 8 | Unsigned right-shift amount |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_mant | output | 128 | Shifted mantissa |
| out_sticky | output | 1 | Incoming sticky OR all discarded bits |
| out_err | output | 1 | Set when the shift amount was zero |

## Verification
Every result appears at the outputs on the same rising edge that accepts its operand, so it can be checked exactly one cycle later. The bench drives inputs on falling edges, lets exactly one rising edge pass, and samples `out_valid`, `out_mant`, `out_sticky` and `out_err` on the next falling edge. It then samples again one cycle later to confirm that the done pulse has ended. The stall test holds `out_ready` low for several cycles and samples on each falling edge in between, to confirm that the result does not change and that `in_ready` stays low. It then checks that a second operand queued behind the stall appears one cycle after `out_ready` returns.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 4;
  localparam int MANT_W  = WORD_W * NWORDS;
  localparam int AMT_W   = 8;
  localparam int WSEL_W  = $clog2(NWORDS);
  localparam int BSEL_W  = $clog2(WORD_W);

  typedef logic [MANT_W-1:0] mant_t;

  typedef struct packed {
    mant_t mant;
    logic  sticky;
    logic  err;
  } shres_t;
endpackage

// File: rtl/mrs_word_mover.sv
module mrs_word_mover #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int SEL_W  = 2,
  localparam int TOT_W = WORD_W * NWORDS
) (
  input  logic [TOT_W-1:0] din,
  input  logic [SEL_W-1:0] nmove,
  output logic [TOT_W-1:0] dout,
  output logic             lost
);
  logic [WORD_W-1:0] w_in  [NWORDS];
  logic [WORD_W-1:0] w_out [NWORDS];

  // word 0 is the most significant slice
  for (genvar g = 0; g < NWORDS; g++) begin : g_words
    assign w_in[g] = din[(NWORDS-g)*WORD_W-1 -: WORD_W];
    assign dout[(NWORDS-g)*WORD_W-1 -: WORD_W] = w_out[g];
  end

  always_comb begin
    lost = 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      w_out[i] = '0;
      if (i >= int'(nmove)) w_out[i] = w_in[i - int'(nmove)];
      if (i >= NWORDS - int'(nmove)) lost = lost | (|w_in[i]);
    end
  end
endmodule

// File: rtl/mrs_bit_shifter.sv
module mrs_bit_shifter #(
  parameter int DATA_W = 128,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] dout,
  output logic              lost
);
  logic [DATA_W-1:0] stg [SH_W+1];
  logic [SH_W:0]     gone;

  assign stg[0]  = din;
  assign gone[0] = 1'b0;

  // logarithmic stages; each drops the 2^j low bits it shifts out
  for (genvar j = 0; j < SH_W; j++) begin : g_stage
    localparam int DIST = 1 << j;
    assign stg[j+1]  = sh[j] ? (stg[j] >> DIST) : stg[j];
    assign gone[j+1] = gone[j] | (sh[j] & (|stg[j][DIST-1:0]));
  end

  assign dout = stg[SH_W];
  assign lost = gone[SH_W];
endmodule

// File: rtl/mrs_out_stage.sv
module mrs_out_stage #(
  parameter int DATA_W = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (take) begin
        dn_valid <= 1'b1;
        dn_data  <= up_data;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mant_rshift_sticky.sv
module mant_rshift_sticky
  import mrs_pkg::*;
#(
  parameter int NSIG = 115
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MANT_W-1:0]   in_mant,
  input  logic                in_sticky,
  input  logic [AMT_W-1:0]    in_amt,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MANT_W-1:0]   out_mant,
  output logic                out_sticky,
  output logic                out_err
);
  localparam int RES_W = $bits(shres_t);

  logic              amt_zero;
  logic              amt_flush;
  logic [WSEL_W-1:0] word_sel;
  logic [BSEL_W-1:0] bit_sel;
  mant_t             mid_mant, fin_mant;
  logic              lost_words, lost_bits;
  shres_t            nxt, cur;

  assign amt_zero  = (in_amt == '0);
  // a whole-word count cannot exceed the word array; the flush covers the rest
  assign amt_flush = (int'(in_amt) >= NSIG) || (int'(in_amt) >= MANT_W);
  assign word_sel  = in_amt[BSEL_W +: WSEL_W];
  assign bit_sel   = in_amt[BSEL_W-1:0];

  mrs_word_mover #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS),
    .SEL_W  (WSEL_W)
  ) u_words (
    .din   (in_mant),
    .nmove (word_sel),
    .dout  (mid_mant),
    .lost  (lost_words)
  );

  mrs_bit_shifter #(
    .DATA_W (MANT_W),
    .SH_W   (BSEL_W)
  ) u_bits (
    .din  (mid_mant),
    .sh   (bit_sel),
    .dout (fin_mant),
    .lost (lost_bits)
  );

  always_comb begin
    if (amt_zero) begin
      nxt.mant   = in_mant;
      nxt.sticky = in_sticky;
      nxt.err    = 1'b1;
    end else if (amt_flush) begin
      nxt.mant   = '0;
      nxt.sticky = 1'b1;
      nxt.err    = 1'b0;
    end else begin
      nxt.mant   = fin_mant;
      nxt.sticky = in_sticky | lost_words | lost_bits;
      nxt.err    = 1'b0;
    end
  end

  mrs_out_stage #(
    .DATA_W (RES_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (nxt),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (cur)
  );

  assign out_mant   = cur.mant;
  assign out_sticky = cur.sticky;
  assign out_err    = cur.err;
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
  parameter int NSIG = 115
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [127:0] in_mant,
  input logic         in_sticky,
  input logic [7:0]   in_amt,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_mant,
  input logic         out_sticky,
  input logic         out_err
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_SHIFT_VALUE: assert property (@(posedge clk) disable iff (rst)
    acc && in_amt != 8'd0 && int'(in_amt) < NSIG |=> out_mant == ($past(in_mant) >> $past(in_amt))); // R1
  AST_STICKY_CARRY: assert property (@(posedge clk) disable iff (rst)
    acc && in_sticky |=> out_sticky); // R2
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    acc && int'(in_amt) >= NSIG |=> out_mant == '0 && out_sticky && !out_err); // R3
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    acc && in_amt == 8'd0 |=> out_err && out_mant == $past(in_mant) && out_sticky == $past(in_sticky)); // R4
  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R5
  AST_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !acc |=> !out_valid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_sticky) && $stable(out_err)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && out_mant == '0 && !out_sticky && !out_err); // R7
  AST_ERR_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    acc && in_amt != 8'd0 |=> !out_err); // R8
endmodule

bind mant_rshift_sticky mrs_checker #(.NSIG(NSIG)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_mant    (in_mant),
  .in_sticky  (in_sticky),
  .in_amt     (in_amt),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_mant   (out_mant),
  .out_sticky (out_sticky),
  .out_err    (out_err)
);

// File: tb/tb_mant_rshift_sticky.sv
`timescale 1ns/1ps
module tb_mant_rshift_sticky;
  localparam int NSIG = 115;
  localparam int NV   = 16;

  // {sticky_in, amount, mantissa}
  localparam logic [136:0] VECS [NV] = '{
    {1'b0, 8'd1,   128'h8000_0000_0000_0000_0000_0000_0000_0001},
    {1'b0, 8'd31,  128'hFFFF_FFFF_0000_0000_0000_0000_0000_0000},
    {1'b0, 8'd32,  128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {1'b0, 8'd33,  128'h0123_4567_89AB_CDEF_FEDC_BA98_0000_0000},
    {1'b0, 8'd63,  128'hDEAD_BEEF_CAFE_F00D_8000_0000_0000_0000},
    {1'b0, 8'd64,  128'h0007_FFFF_FFFF_FFFF_0000_0000_0000_0000},
    {1'b1, 8'd64,  128'h0007_FFFF_FFFF_FFFF_0000_0000_0000_0000},
    {1'b0, 8'd96,  128'hA5A5_A5A5_0000_0000_0000_0000_0000_0000},
    {1'b0, 8'd96,  128'hA5A5_A5A5_0000_0000_0000_0000_0000_0001},
    {1'b0, 8'd114, 128'h0004_0000_0000_0000_0000_0000_0000_0000},
    {1'b0, 8'd115, 128'h0004_0000_0000_0000_0000_0000_0000_0000},
    {1'b0, 8'd255, 128'h0000_0000_0000_0000_0000_0000_0000_0000},
    {1'b1, 8'd0,   128'h1357_9BDF_0246_8ACE_1111_2222_3333_4444},
    {1'b0, 8'd0,   128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000},
    {1'b0, 8'd5,   128'h0000_0000_0000_0000_0000_0000_0000_0020},
    {1'b0, 8'd97,  128'h7FFF_FFFF_1234_5678_0000_0000_0000_0000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_mant = '0;
  logic         in_sticky = 1'b0;
  logic [7:0]   in_amt = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_mant;
  logic         out_sticky;
  logic         out_err;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  mant_rshift_sticky #(.NSIG(NSIG)) dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_mant    (in_mant),
    .in_sticky  (in_sticky),
    .in_amt     (in_amt),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_mant   (out_mant),
    .out_sticky (out_sticky),
    .out_err    (out_err)
  );

  // returns {err, sticky, mantissa}
  function automatic logic [129:0] ref_model(input logic [127:0] m, input logic s, input logic [7:0] a);
    logic [255:0] wide;
    if (a == 8'd0) return {1'b1, s, m};
    if (int'(a) >= NSIG) return {1'b0, 1'b1, 128'h0};
    wide = {m, 128'h0} >> a;
    return {1'b0, s | (|wide[127:0]), wide[255:128]};
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_mant(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] m, input logic s, input logic [7:0] a);
    in_valid  = 1'b1;
    in_mant   = m;
    in_sticky = s;
    in_amt    = a;
  endtask

  initial begin
    logic [129:0] e, e2;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check_bit("R7 out_valid after reset", out_valid, 1'b0);
    check_mant("R7 out_mant after reset", out_mant, '0);
    check_bit("R7 out_sticky after reset", out_sticky, 1'b0);
    check_bit("R7 out_err after reset", out_err, 1'b0);
    check_bit("R7 in_ready after reset", in_ready, 1'b1);

    // table walk: result due one edge after acceptance
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][127:0], VECS[i][136], VECS[i][135:128]);
      e = ref_model(VECS[i][127:0], VECS[i][136], VECS[i][135:128]);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R5 out_valid due", out_valid, 1'b1);
      if (VECS[i][135:128] == 8'd0) begin
        check_mant("R4 zero amount passthrough", out_mant, e[127:0]);
        check_bit("R4 zero amount err", out_err, 1'b1);
        check_bit("R4 zero amount sticky", out_sticky, e[128]);
      end else if (int'(VECS[i][135:128]) >= NSIG) begin
        check_mant("R3 flush mant", out_mant, e[127:0]);
        check_bit("R3 flush sticky", out_sticky, 1'b1);
        check_bit("R8 flush err", out_err, 1'b0);
      end else begin
        check_mant("R1 shifted mant", out_mant, e[127:0]);
        check_bit("R2 sticky", out_sticky, e[128]);
        check_bit("R8 err", out_err, 1'b0);
      end
      @(negedge clk);
      check_bit("R5 done pulse ends", out_valid, 1'b0);
    end

    // back-to-back operands, one per cycle
    drive(VECS[2][127:0], 1'b0, 8'd40);
    @(negedge clk);
    e = ref_model(VECS[2][127:0], 1'b0, 8'd40);
    drive(VECS[2][127:0], 1'b1, 8'd7);
    check_mant("R1 back-to-back first", out_mant, e[127:0]);
    @(negedge clk);
    in_valid = 1'b0;
    e = ref_model(VECS[2][127:0], 1'b1, 8'd7);
    check_bit("R5 back-to-back valid", out_valid, 1'b1);
    check_mant("R1 back-to-back second", out_mant, e[127:0]);
    check_bit("R2 back-to-back sticky", out_sticky, 1'b1);
    @(negedge clk);

    // R6: stall holds the result and blocks the input side
    out_ready = 1'b0;
    drive(128'hFEDC_0000_0000_0000_0000_0000_0000_00FF, 1'b0, 8'd8);
    e = ref_model(128'hFEDC_0000_0000_0000_0000_0000_0000_00FF, 1'b0, 8'd8);
    @(negedge clk);
    drive(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 1'b0, 8'd100);
    e2 = ref_model(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 1'b0, 8'd100);
    held = out_mant;
    check_mant("R1 stalled result", held, e[127:0]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_bit("R6 in_ready low in stall", in_ready, 1'b0);
      check_bit("R6 out_valid held", out_valid, 1'b1);
      check_mant("R6 out_mant held", out_mant, e[127:0]);
      check_bit("R6 out_sticky held", out_sticky, e[128]);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_mant("R6 queued operand after release", out_mant, e2[127:0]);
    check_bit("R6 queued sticky after release", out_sticky, e2[128]);
    @(negedge clk);
    check_bit("R5 valid drops after release", out_valid, 1'b0);

    // R7: reset while a result is held
    out_ready = 1'b0;
    drive(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 8'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_bit("R7 mid-run reset valid", out_valid, 1'b0);
    check_mant("R7 mid-run reset mant", out_mant, '0);
    check_bit("R7 mid-run reset err", out_err, 1'b0);
    check_bit("R7 mid-run reset sticky", out_sticky, 1'b0);
    out_ready = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule